// File: doc/BRIEF.md
# SDR SDRAM Power-Up Initialisation Sequencer

This block takes a single-data-rate SDRAM from power-on to normal operation. After reset it holds the clock enable low for a stable-power wait, then raises it and issues idle (NOP) commands for a second wait. It then precharges every bank. A short burst of auto-refresh commands follows, and the mode register is loaded. Once the mode-register delay has passed, it raises `init_done`. A memory controller uses `init_done` as the point from which it may start normal accesses and enable its data buffers. After that the block keeps issuing auto-refresh commands at the real refresh interval.

The refresh timer counts in units of 16 clocks. Right after the precharge-all it is loaded with a very short reload value, so that several refreshes happen close together inside a fixed window. When the window closes, the timer is reloaded with the real interval: the refresh period in clock cycles, divided by 16. All nanosecond timing values are rounded up to whole clock cycles and published on a flat vector for the downstream access logic. The mode word is built on an internal system-address word whose row field starts at bit `ROW_LSB` (12 by default). It reaches the SDRAM address pins from bit 0.

The state machine has seven states:

| From | To | Condition |
| --- | --- | --- |
| ST_POWER_WAIT | ST_NOP_WAIT | the power wait count has expired |
| ST_NOP_WAIT | ST_PRECHARGE | the NOP wait count has expired |
| ST_PRECHARGE | ST_REFRESH_BURST | always; this state issues precharge-all for one cycle |
| ST_REFRESH_BURST | ST_REFRESH_BURST | a refresh is pending and the command gap has elapsed; it issues auto-refresh |
| ST_REFRESH_BURST | ST_MODE_SET | the window has expired, the gap has elapsed and no refresh is being issued |
| ST_MODE_SET | ST_MODE_DELAY | always; this state issues mode-register-set for one cycle |
| ST_MODE_DELAY | ST_RUN | the mode-register delay has elapsed |
| ST_RUN | ST_RUN | it issues auto-refresh whenever one is pending and the gap has elapsed |

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: `cke`=0, NOP on the command pins (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1), `addr`=0, `ba`=0 and `init_done`=0.
- R2: After reset is released, `cke` stays low with NOP for between PWR_WAIT_CYC and PWR_WAIT_CYC+2 sampled cycles, then goes high. Whenever `cke` is low, the command is NOP.
- R3: At least NOP_WAIT_CYC cycles of NOP separate the rise of `cke` from the first non-NOP command. That command is precharge-all (`cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0) with `addr[10]`=1.
- R4: Auto-refresh is encoded as `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1. During the init burst window, consecutive auto-refreshes are INIT_REF_RELOAD×16 cycles apart, which is 32 by default.
- R5: A command after precharge-all is at least ceil(tRP) cycles later. A command after auto-refresh is at least max(ceil(tRFC), ceil(tRC)) cycles later. A command after mode-register-set is at least tMRD cycles later.
- R6: Mode-register-set comes no earlier than BURST_CYC cycles after precharge-all, and at least two auto-refreshes lie between the two.
- R7: Mode-register-set has all four command pins low and `ba`=0. On `addr`, bits [2:0] carry the burst-length code (3, for 8 beats), bit 3=0 selects sequential burst, and bits [6:4] carry CAS latency 3, so `addr`=0x033. This value is taken from the internal address word starting at bit ROW_LSB.
- R8: `init_done` rises no earlier than tMRD cycles after mode-register-set. It stays high until the next reset.
- R9: After initialisation, consecutive auto-refreshes are (ceil(T_REF_NS×CLK_MHZ/1000) >> 4) × 16 cycles apart, which is 368 at 50 MHz.
- R10: Field k of `timing_cyc` occupies bits [k×5+4 : k×5]. The fields are:

  | Field | Content |
  | --- | --- |
  | 0 | tRP |
  | 1 | tRAS |
  | 2 | self-refresh exit |
  | 3 | tAPR (2, given in cycles) |
  | 4 | tDAL (2 plus tRP cycles) |
  | 5 | tWR |
  | 6 | tRC |
  | 7 | tRFC |
  | 8 | tXSR |
  | 9 | tRRD |
  | 10 | tMRD (2, given in cycles) |
  | 11 | RAS latency (3) |

  Every field given in nanoseconds holds ceil(ns×CLK_MHZ/1000).
- R11: Only NOP, precharge-all, auto-refresh and mode-register-set ever appear on the command pins.
- R12: Asserting `rst_n` in the middle of operation immediately returns `cke` and `init_done` to 0. Releasing it restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select |
| addr | output | ADDR_W | SDRAM address pins |
| init_done | output | 1 | High once normal accesses may begin |
| timing_cyc | output | 12×TCYC_W | Timing parameters converted to cycles |

## Verification
The bound checker watches the command pins on every cycle for the following:
- only the four legal codes appear;
- NOP is held while `cke` is low;
- `addr[10]` is set on precharge-all;
- the mode-word fields are correct on mode-register-set;
- the minimum gaps after precharge-all, auto-refresh and mode-register-set are respected;
- `init_done` follows the mode delay and never drops.

Only the bench's scenarios can show the rest. These are the lengths of the two power waits, the 32-cycle burst spacing, the window before mode-register-set, the exact run-time refresh interval, the converted timing values, and the full restart after a mid-run reset.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PALL = 2'd1,
        CMD_AREF = 2'd2,
        CMD_MRS  = 2'd3
    } init_cmd_e;

    typedef enum logic [2:0] {
        ST_POWER_WAIT,
        ST_NOP_WAIT,
        ST_PRECHARGE,
        ST_REFRESH_BURST,
        ST_MODE_SET,
        ST_MODE_DELAY,
        ST_RUN
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    // number of fields published on the timing vector
    localparam int unsigned NUM_TFIELDS = 12;

    // field indices
    localparam int unsigned TF_RP   = 0;
    localparam int unsigned TF_RC   = 6;
    localparam int unsigned TF_RFC  = 7;
    localparam int unsigned TF_MRD  = 10;

    // field source kinds
    localparam int unsigned KIND_NS      = 0;
    localparam int unsigned KIND_CYC     = 1;
    localparam int unsigned KIND_CYC_RP  = 2;

    // ceiling conversion of nanoseconds to cycles, never below one cycle
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic cmd_pins_t encode_cmd(input init_cmd_e c);
        cmd_pins_t p;
        unique case (c)
            CMD_NOP:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_AREF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_MRS:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sdr_timing_table.sv
module sdr_timing_table
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 50,
    parameter int unsigned TCYC_W    = 5,
    parameter int unsigned REF_W     = 8,
    parameter int unsigned T_RP_NS   = 24,
    parameter int unsigned T_RAS_NS  = 40,
    parameter int unsigned T_SREX_NS = 78,
    parameter int unsigned T_APR_CYC = 2,
    parameter int unsigned T_DAL_CYC = 2,
    parameter int unsigned T_WR_NS   = 18,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_RFC_NS  = 70,
    parameter int unsigned T_XSR_NS  = 78,
    parameter int unsigned T_RRD_NS  = 18,
    parameter int unsigned T_MRD_CYC = 2,
    parameter int unsigned RAS_LAT   = 3,
    parameter int unsigned T_REF_NS  = 7513
) (
    output logic [NUM_TFIELDS*TCYC_W-1:0] timing_cyc,
    output logic [TCYC_W-1:0]             gap_rp,
    output logic [TCYC_W-1:0]             gap_aref,
    output logic [TCYC_W-1:0]             gap_mrd,
    output logic [REF_W-1:0]              ref_reload
);

    localparam int unsigned SRC [NUM_TFIELDS] = '{
        T_RP_NS, T_RAS_NS, T_SREX_NS, T_APR_CYC, T_DAL_CYC, T_WR_NS,
        T_RC_NS, T_RFC_NS, T_XSR_NS, T_RRD_NS, T_MRD_CYC, RAS_LAT
    };
    localparam int unsigned KIND [NUM_TFIELDS] = '{
        KIND_NS, KIND_NS, KIND_NS, KIND_CYC, KIND_CYC_RP, KIND_NS,
        KIND_NS, KIND_NS, KIND_NS, KIND_NS, KIND_CYC, KIND_CYC
    };

    localparam int unsigned RP_CYC  = ns_to_cycles(T_RP_NS, CLK_MHZ);
    localparam int unsigned RC_CYC  = ns_to_cycles(T_RC_NS, CLK_MHZ);
    localparam int unsigned RFC_CYC = ns_to_cycles(T_RFC_NS, CLK_MHZ);
    localparam int unsigned AREF_GAP = (RFC_CYC > RC_CYC) ? RFC_CYC : RC_CYC;
    localparam int unsigned REF_CYC = ns_to_cycles(T_REF_NS, CLK_MHZ);

    for (genvar k = 0; k < NUM_TFIELDS; k++) begin : g_field
        localparam int unsigned VAL =
            (KIND[k] == KIND_NS)  ? ns_to_cycles(SRC[k], CLK_MHZ) :
            (KIND[k] == KIND_CYC) ? SRC[k] : SRC[k] + RP_CYC;
        assign timing_cyc[k*TCYC_W +: TCYC_W] = TCYC_W'(VAL);
    end

    assign gap_rp     = TCYC_W'(RP_CYC);
    assign gap_aref   = TCYC_W'(AREF_GAP);
    assign gap_mrd    = TCYC_W'(T_MRD_CYC);
    assign ref_reload = REF_W'(REF_CYC >> 4);

endmodule

// File: rtl/sdr_down_counter.sv
module sdr_down_counter #(
    parameter int unsigned W         = 8,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int unsigned RELOAD_W  = 8,
    parameter int unsigned PRESCALE  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RELOAD_W-1:0] reload_val,
    output logic                tick
);

    localparam int unsigned CNT_W = RELOAD_W + PRESCALE;

    logic                armed_q;
    logic [RELOAD_W-1:0] reload_q;
    logic [CNT_W-1:0]    cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            armed_q  <= 1'b1;
            reload_q <= reload_val;
            cnt_q    <= {reload_val, {PRESCALE{1'b0}}} - 1'b1;
        end else if (armed_q) begin
            if (cnt_q == '0) begin
                cnt_q <= {reload_q, {PRESCALE{1'b0}}} - 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign tick = armed_q && !load && (cnt_q == '0);

endmodule

// File: rtl/sdr_cmd_encoder.sv
module sdr_cmd_encoder
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned BA_W    = 2,
    parameter int unsigned ROW_LSB = 12,
    parameter int unsigned SRC_W   = ROW_LSB + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  init_cmd_e         cmd,
    input  logic              cke_d,
    input  logic              done_d,
    input  logic [SRC_W-1:0]  src_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    cmd_pins_t pins_d;
    assign pins_d = encode_cmd(cmd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke       <= 1'b0;
            cs_n      <= 1'b0;
            ras_n     <= 1'b1;
            cas_n     <= 1'b1;
            we_n      <= 1'b1;
            ba        <= '0;
            addr      <= '0;
            init_done <= 1'b0;
        end else begin
            cke       <= cke_d;
            cs_n      <= pins_d.cs_n;
            ras_n     <= pins_d.ras_n;
            cas_n     <= pins_d.cas_n;
            we_n      <= pins_d.we_n;
            ba        <= '0;
            addr      <= src_word[ROW_LSB +: ADDR_W];
            init_done <= done_d;
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ         = 50,
    parameter int unsigned ADDR_W          = 13,
    parameter int unsigned BA_W            = 2,
    parameter int unsigned TCYC_W          = 5,
    parameter int unsigned REF_W           = 8,
    parameter int unsigned PWR_WAIT_CYC    = 5000,
    parameter int unsigned NOP_WAIT_CYC    = 10000,
    parameter int unsigned BURST_CYC       = 256,
    parameter int unsigned INIT_REF_RELOAD = 2,
    parameter int unsigned T_RP_NS         = 24,
    parameter int unsigned T_RAS_NS        = 40,
    parameter int unsigned T_SREX_NS       = 78,
    parameter int unsigned T_APR_CYC       = 2,
    parameter int unsigned T_DAL_CYC       = 2,
    parameter int unsigned T_WR_NS         = 18,
    parameter int unsigned T_RC_NS         = 70,
    parameter int unsigned T_RFC_NS        = 70,
    parameter int unsigned T_XSR_NS        = 78,
    parameter int unsigned T_RRD_NS        = 18,
    parameter int unsigned T_MRD_CYC       = 2,
    parameter int unsigned RAS_LAT         = 3,
    parameter int unsigned CAS_LAT         = 3,
    parameter int unsigned BURST_CODE      = 3,
    parameter int unsigned T_REF_NS        = 7513,
    parameter int unsigned ROW_LSB         = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          cke,
    output logic                          cs_n,
    output logic                          ras_n,
    output logic                          cas_n,
    output logic                          we_n,
    output logic [BA_W-1:0]               ba,
    output logic [ADDR_W-1:0]             addr,
    output logic                          init_done,
    output logic [NUM_TFIELDS*TCYC_W-1:0] timing_cyc
);

    localparam int unsigned MAX_WAIT =
        (PWR_WAIT_CYC > NOP_WAIT_CYC) ?
            ((PWR_WAIT_CYC > BURST_CYC) ? PWR_WAIT_CYC : BURST_CYC) :
            ((NOP_WAIT_CYC > BURST_CYC) ? NOP_WAIT_CYC : BURST_CYC);
    localparam int unsigned MAIN_W   = $clog2(MAX_WAIT + 1);
    localparam int unsigned SRC_W    = ROW_LSB + ADDR_W;
    localparam int unsigned MODE_VAL = (CAS_LAT << 4) | BURST_CODE;
    localparam logic [SRC_W-1:0] MODE_WORD = SRC_W'(MODE_VAL) << ROW_LSB;
    localparam logic [SRC_W-1:0] PALL_WORD = SRC_W'(1) << (ROW_LSB + 10);

    // timing constants
    logic [TCYC_W-1:0] gap_rp, gap_aref, gap_mrd;
    logic [REF_W-1:0]  ref_normal;

    sdr_timing_table #(
        .CLK_MHZ(CLK_MHZ), .TCYC_W(TCYC_W), .REF_W(REF_W),
        .T_RP_NS(T_RP_NS), .T_RAS_NS(T_RAS_NS), .T_SREX_NS(T_SREX_NS),
        .T_APR_CYC(T_APR_CYC), .T_DAL_CYC(T_DAL_CYC), .T_WR_NS(T_WR_NS),
        .T_RC_NS(T_RC_NS), .T_RFC_NS(T_RFC_NS), .T_XSR_NS(T_XSR_NS),
        .T_RRD_NS(T_RRD_NS), .T_MRD_CYC(T_MRD_CYC), .RAS_LAT(RAS_LAT),
        .T_REF_NS(T_REF_NS)
    ) u_table (
        .timing_cyc (timing_cyc),
        .gap_rp     (gap_rp),
        .gap_aref   (gap_aref),
        .gap_mrd    (gap_mrd),
        .ref_reload (ref_normal)
    );

    // control signals
    init_state_e       state_q, state_d;
    init_cmd_e         cmd;
    logic              cke_d, done_d;
    logic [SRC_W-1:0]  src_word;
    logic              main_load, main_zero;
    logic [MAIN_W-1:0] main_val;
    logic              gap_load, gap_zero;
    logic [TCYC_W-1:0] gap_val;
    logic              ref_load, ref_tick, ref_pend_q, pend_clr;
    logic [REF_W-1:0]  ref_val;
    logic              aref_go;

    sdr_down_counter #(.W(MAIN_W), .RESET_VAL(PWR_WAIT_CYC - 1)) u_main_cnt (
        .clk(clk), .rst_n(rst_n), .load(main_load), .load_val(main_val), .is_zero(main_zero)
    );

    sdr_down_counter #(.W(TCYC_W), .RESET_VAL(0)) u_gap_cnt (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .is_zero(gap_zero)
    );

    sdr_refresh_timer #(.RELOAD_W(REF_W), .PRESCALE(4)) u_ref_timer (
        .clk(clk), .rst_n(rst_n), .load(ref_load), .reload_val(ref_val), .tick(ref_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ref_pend_q <= 1'b0;
        else if (ref_tick) ref_pend_q <= 1'b1;
        else if (pend_clr) ref_pend_q <= 1'b0;
    end

    assign aref_go = ref_pend_q && gap_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POWER_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWER_WAIT:    if (main_zero) state_d = ST_NOP_WAIT;
            ST_NOP_WAIT:      if (main_zero) state_d = ST_PRECHARGE;
            ST_PRECHARGE:     state_d = ST_REFRESH_BURST;
            ST_REFRESH_BURST: if (!aref_go && main_zero && gap_zero) state_d = ST_MODE_SET;
            ST_MODE_SET:      state_d = ST_MODE_DELAY;
            ST_MODE_DELAY:    if (gap_zero) state_d = ST_RUN;
            ST_RUN:           state_d = ST_RUN;
            default:          state_d = ST_POWER_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        cke_d     = 1'b1;
        done_d    = 1'b0;
        src_word  = '0;
        main_load = 1'b0;
        main_val  = '0;
        gap_load  = 1'b0;
        gap_val   = '0;
        ref_load  = 1'b0;
        ref_val   = '0;
        pend_clr  = 1'b0;
        unique case (state_q)
            ST_POWER_WAIT: begin
                cke_d = 1'b0;
                if (main_zero) begin
                    main_load = 1'b1;
                    main_val  = MAIN_W'(NOP_WAIT_CYC - 1);
                end
            end
            ST_NOP_WAIT: ;
            ST_PRECHARGE: begin
                cmd       = CMD_PALL;
                src_word  = PALL_WORD;
                main_load = 1'b1;
                main_val  = MAIN_W'(BURST_CYC - 1);
                gap_load  = 1'b1;
                gap_val   = gap_rp - 1'b1;
                ref_load  = 1'b1;
                ref_val   = REF_W'(INIT_REF_RELOAD);
            end
            ST_REFRESH_BURST: begin
                if (aref_go) begin
                    cmd      = CMD_AREF;
                    gap_load = 1'b1;
                    gap_val  = gap_aref - 1'b1;
                    pend_clr = 1'b1;
                end else if (main_zero && gap_zero) begin
                    ref_load = 1'b1;
                    ref_val  = ref_normal;
                end
            end
            ST_MODE_SET: begin
                cmd      = CMD_MRS;
                src_word = MODE_WORD;
                gap_load = 1'b1;
                gap_val  = gap_mrd - 1'b1;
            end
            ST_MODE_DELAY: ;
            ST_RUN: begin
                done_d = 1'b1;
                if (aref_go) begin
                    cmd      = CMD_AREF;
                    gap_load = 1'b1;
                    gap_val  = gap_aref - 1'b1;
                    pend_clr = 1'b1;
                end
            end
            default: cke_d = 1'b0;
        endcase
    end

    sdr_cmd_encoder #(.ADDR_W(ADDR_W), .BA_W(BA_W), .ROW_LSB(ROW_LSB), .SRC_W(SRC_W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .cke_d     (cke_d),
        .done_d    (done_d),
        .src_word  (src_word),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .init_done (init_done)
    );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned GAP_W      = 5,
    parameter int unsigned CAS_LAT    = 3,
    parameter int unsigned BURST_CODE = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done,
    input logic [GAP_W-1:0]  gap_rp,
    input logic [GAP_W-1:0]  gap_aref,
    input logic [GAP_W-1:0]  gap_mrd
);

    localparam int unsigned CNT_W = GAP_W + 3;
    localparam logic [1:0] L_NONE = 2'd0;
    localparam logic [1:0] L_PALL = 2'd1;
    localparam logic [1:0] L_AREF = 2'd2;
    localparam logic [1:0] L_MRS  = 2'd3;

    logic is_nop, is_pall, is_aref, is_mrs, busy;
    assign is_nop  = !cs_n &&  ras_n &&  cas_n &&  we_n;
    assign is_pall = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_aref = !cs_n && !ras_n && !cas_n &&  we_n;
    assign is_mrs  = !cs_n && !ras_n && !cas_n && !we_n;
    assign busy    = is_pall || is_aref || is_mrs;

    logic [1:0]       last_q;
    logic [CNT_W-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q  <= L_NONE;
            since_q <= '0;
        end else if (busy) begin
            last_q  <= is_pall ? L_PALL : (is_aref ? L_AREF : L_MRS);
            since_q <= CNT_W'(1);
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r11_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop || busy);

    a_r2_cke_low_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> is_nop);

    a_r3_pall_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |-> addr[10]);

    a_r7_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (addr[6:4] == 3'(CAS_LAT) && !addr[3] && addr[2:0] == 3'(BURST_CODE)));

    a_r5_gap_after_pall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_q == L_PALL) |-> since_q >= CNT_W'(gap_rp));

    a_r5_gap_after_aref: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_q == L_AREF) |-> since_q >= CNT_W'(gap_aref));

    a_r5_gap_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_q == L_MRS) |-> since_q >= CNT_W'(gap_mrd));

    a_r8_done_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (last_q == L_MRS && since_q >= CNT_W'(gap_mrd)));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W(ADDR_W), .GAP_W(TCYC_W), .CAS_LAT(CAS_LAT), .BURST_CODE(BURST_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .init_done(init_done),
    .gap_rp(gap_rp), .gap_aref(gap_aref), .gap_mrd(gap_mrd)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

    localparam int MHZ    = 50;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int TW     = 5;
    localparam int NF     = 12;
    localparam int PWR    = 20;
    localparam int NOPW   = 30;
    localparam int BURST  = 256;
    localparam int WD_MAX = 20000;

    // timing table vectors: source value and kind (0 ns, 1 cycles, 2 cycles plus tRP)
    localparam int TBL_SRC  [NF] = '{24, 40, 78, 2, 2, 18, 70, 70, 78, 18, 2, 3};
    localparam int TBL_KIND [NF] = '{0, 0, 0, 1, 2, 0, 0, 0, 0, 0, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BA_W-1:0] ba;
    logic [ADDR_W-1:0] addr;
    logic [NF*TW-1:0] timing_cyc;

    always #10 clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ(MHZ), .ADDR_W(ADDR_W), .BA_W(BA_W), .TCYC_W(TW),
        .PWR_WAIT_CYC(PWR), .NOP_WAIT_CYC(NOPW), .BURST_CYC(BURST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .init_done(init_done), .timing_cyc(timing_cyc)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    function automatic int ceil_cyc(input int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pin monitor
    int cyc, cke_low_n, cke_rise_t, pall_t, pall_a10, mrs_t, mrs_addr, mrs_ba, done_t;
    int n_pre, n_post, illegal_n, done_falls, min_after_aref, prev_t, prev_kind;
    int pre_t [0:15];
    int post_t [0:15];
    bit prev_done;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; cke_low_n = 0; cke_rise_t = -1; pall_t = -1; mrs_t = -1;
            done_t = -1; n_pre = 0; n_post = 0; illegal_n = 0; done_falls = 0;
            min_after_aref = 1000; prev_t = -1; prev_kind = 0; prev_done = 0;
            pall_a10 = 0; mrs_addr = 0; mrs_ba = 0;
        end else begin
            int kind;
            kind = 0;
            if (!cke && cke_rise_t < 0) cke_low_n++;
            if (cke && cke_rise_t < 0) cke_rise_t = cyc;
            if (cs_n) illegal_n++;
            else if (ras_n && cas_n && we_n) kind = 0;
            else if (!ras_n && cas_n && !we_n) kind = 1;
            else if (!ras_n && !cas_n && we_n) kind = 2;
            else if (!ras_n && !cas_n && !we_n) kind = 3;
            else illegal_n++;
            if (!cke && kind != 0) illegal_n++;
            if (kind != 0) begin
                if (prev_kind == 2 && (cyc - prev_t) < min_after_aref) min_after_aref = cyc - prev_t;
                prev_kind = kind;
                prev_t = cyc;
            end
            if (kind == 1 && pall_t < 0) begin pall_t = cyc; pall_a10 = int'(addr[10]); end
            if (kind == 2 && mrs_t < 0 && n_pre < 16) begin pre_t[n_pre] = cyc; n_pre++; end
            else if (kind == 2 && mrs_t >= 0 && n_post < 16) begin post_t[n_post] = cyc; n_post++; end
            if (kind == 3) begin mrs_t = cyc; mrs_addr = int'(addr); mrs_ba = int'(ba); end
            if (init_done && done_t < 0) done_t = cyc;
            if (prev_done && !init_done) done_falls++;
            prev_done = init_done;
            cyc++;
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == WD_MAX && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", wd, WD_MAX);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check_sequence();
        while (n_post < 3) @(negedge clk);
        @(negedge clk);
        chk(cke_low_n >= PWR && cke_low_n <= PWR + 2, "R2 cke low span", cke_low_n, PWR);
        chk(pall_t - cke_rise_t >= NOPW, "R3 nop wait", pall_t - cke_rise_t, NOPW);
        chk(pall_a10 == 1, "R3 precharge-all addr10", pall_a10, 1);
        chk(pre_t[1] - pre_t[0] == 32, "R4 burst refresh spacing", pre_t[1] - pre_t[0], 32);
        chk(pre_t[0] - pall_t >= ceil_cyc(24), "R5 gap after precharge", pre_t[0] - pall_t, ceil_cyc(24));
        chk(min_after_aref >= ceil_cyc(70), "R5 gap after refresh", min_after_aref, ceil_cyc(70));
        chk(mrs_t - pall_t >= BURST, "R6 window before mode", mrs_t - pall_t, BURST);
        chk(n_pre >= 2, "R6 refresh count in window", n_pre, 2);
        chk(mrs_addr == 'h033 && mrs_ba == 0, "R7 mode word", mrs_addr, 'h033);
        chk(done_t - mrs_t >= 2, "R8 done after mode delay", done_t - mrs_t, 2);
        chk(done_falls == 0 && init_done, "R8 done stays high", done_falls, 0);
        chk(post_t[2] - post_t[1] == ((ceil_cyc(7513) >> 4) * 16), "R9 run refresh interval",
            post_t[2] - post_t[1], (ceil_cyc(7513) >> 4) * 16);
        chk(illegal_n == 0, "R11 illegal commands", illegal_n, 0);
    endtask

    initial begin
        // R1: reset state
        #35;
        chk(!cke && !init_done && addr == 0 && ba == 0, "R1 reset cke/done/addr", int'(cke), 0);
        chk(!cs_n && ras_n && cas_n && we_n, "R1 reset nop", int'({cs_n, ras_n, cas_n, we_n}), 7);

        // R10: walk the timing table
        for (int k = 0; k < NF; k++) begin
            int exp_v;
            int act_v;
            exp_v = (TBL_KIND[k] == 0) ? ceil_cyc(TBL_SRC[k]) :
                    (TBL_KIND[k] == 1) ? TBL_SRC[k] : TBL_SRC[k] + ceil_cyc(24);
            act_v = int'(timing_cyc[k*TW +: TW]);
            chk(act_v == exp_v, $sformatf("R10 timing field %0d", k), act_v, exp_v);
        end

        @(negedge clk); #2 rst_n = 1'b1;
        check_sequence();

        // R12: reset while running
        @(negedge clk); #2 rst_n = 1'b0;
        #1;
        chk(!cke && !init_done, "R12 async reset clears", int'({cke, init_done}), 0);
        #40;
        @(negedge clk); #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!init_done && !cke, "R12 restart begins in power wait", int'({cke, init_done}), 0);
        check_sequence();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule